// File: doc/BRIEF.md
# PLL Output Frequency Decoder

This block turns the settings of a phase-locked loop into the frequency the loop produces. A request carries a control word, a coefficient word, a reference frequency in kHz, a 16-bit fractional-N word and a two-bit mode. When `start` is raised, the block takes a snapshot of all of them. It decodes the feedback multiplier N, the pre-divider M and the post-divider P. It then runs the frequency formula and reports the result with a one-cycle `done` pulse.

The output is `(ref*N + ((((frac + 4096) mod 65536) * ref) >> 13)) / (M * P)`. All intermediate values are held at 48 bits, so nothing overflows. The quotient comes from a bit-serial restoring divider that produces one quotient bit per cycle. A fractional word of 0xF000 makes the fractional term exactly zero, which is the setting for an integer-only loop. The mode input chooses how P is derived: from the coefficient field, forced to one, or from a single coefficient bit. A disabled loop or a zero pre-divider gives a result of zero without running the divider.

Top module: `pllf_decoder`

## Requirements
- R1: With the loop enabled and mode 0, the fields are decoded as P = coef_word[21:16], N = coef_word[15:8] and M = coef_word[7:0]. The result is the exact integer quotient of the formula above.
- R2: When ctrl_word bit 0 is 0 at an accepted start, the result is 0. `done` rises two cycles after the start edge.
- R3: In mode 0 a P field of 0 is used as 1.
- R4: In mode 1, P is 1 whatever coef_word[21:16] holds.
- R5: In mode 2, P is 2 when coef_word bit 28 is 1 and 1 when it is 0. The P field has no effect.
- R6: The fractional term is ((frac_word + 4096) mod 65536) * ref >> 13. frac_word = 0xF000 adds nothing, 0x1000 adds exactly ref, and 0xFFFF wraps to 4095.
- R7: When M is 0 (with the loop enabled), the result is 0. `done` rises two cycles after the start edge.
- R8: A quotient above 0xFFFFFFFF is reported as 0xFFFFFFFF.
- R9: `done` is high for exactly one cycle per accepted request. `freq_khz` holds the last result until the next `done`.
- R10: A `start` raised while a request is in progress is ignored. It produces no result and no `done`.
- R11: Mode 3 derives P exactly as mode 0 does.
- R12: After reset, `done` is 0 and `freq_khz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; operands are captured when it is accepted |
| ctrl_word | input | 32 | Loop control word; bit 0 is the enable |
| coef_word | input | 32 | Coefficient word holding the P, N and M fields and the P-select bit 28 |
| pdiv_mode | input | 2 | 0 = P from field, 1 = P forced to 1, 2 = P from bit 28, 3 = as 0 |
| ref_khz | input | 32 | Reference frequency in kHz |
| frac_word | input | 16 | Fractional-N word (0xF000 for an integer loop) |
| done | output | 1 | One-cycle pulse when freq_khz is updated |
| freq_khz | output | 32 | Decoded output frequency in kHz |

## Verification
The assertions assume that operands matter only in the cycle a start is accepted. They also assume a start during a running request must leave the pipeline untouched, so the bench sometimes changes the operands freely and raises a second start mid-division to test that. The shortcut checks assume the enable bit and the M field are the only operands that bypass the divider, so stimulus covers both with every mode. Apart from the deliberate mid-division start, the stimulus never raises start before the previous result has been reported. This keeps the expected-value queue in step with the stream of results.

// File: rtl/pllf_pkg.sv
package pllf_pkg;
   typedef enum logic [1:0] {
      PDIV_FIELD = 2'd0,
      PDIV_ONE   = 2'd1,
      PDIV_BIT   = 2'd2,
      PDIV_ALT   = 2'd3
   } pdiv_mode_e;
endpackage

// File: rtl/pllf_operand.sv
module pllf_operand
   import pllf_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int REF_W       = 32,
   parameter int FRAC_W      = 16,
   parameter int INTER_W     = 48,
   parameter int P_LSB       = 16,
   parameter int P_W         = 6,
   parameter int N_LSB       = 8,
   parameter int N_W         = 8,
   parameter int M_LSB       = 0,
   parameter int M_W         = 8,
   parameter int PSEL_BIT    = 28,
   parameter int EN_BIT      = 0,
   parameter int FRAC_OFFSET = 4096,
   parameter int FRAC_SHIFT  = 13,
   localparam int DEN_W      = M_W + P_W
) (
   input  logic [WORD_W-1:0]  ctrl_i,
   input  logic [WORD_W-1:0]  coef_i,
   input  logic [1:0]         mode_i,
   input  logic [REF_W-1:0]   ref_i,
   input  logic [FRAC_W-1:0]  frac_i,
   output logic [INTER_W-1:0] num_o,
   output logic [DEN_W-1:0]   den_o,
   output logic               zero_o
);
   if (P_W < 2) begin : g_bad_pw
      $error("P_W must hold the value 2");
   end
   if (INTER_W < REF_W + FRAC_W) begin : g_bad_inter
      $error("INTER_W too narrow for fractional product");
   end
   if (INTER_W < REF_W + N_W + 1) begin : g_bad_inter_n
      $error("INTER_W too narrow for integer product");
   end

   logic [P_W-1:0]     p_fld;
   logic [N_W-1:0]     n_fld;
   logic [M_W-1:0]     m_fld;
   logic [P_W-1:0]     p_eff;
   logic [FRAC_W-1:0]  frac_sum;
   logic [INTER_W-1:0] prod_int;
   logic [INTER_W-1:0] prod_frac;

   assign p_fld = coef_i[P_LSB +: P_W];
   assign n_fld = coef_i[N_LSB +: N_W];
   assign m_fld = coef_i[M_LSB +: M_W];

   always_comb begin
      case (pdiv_mode_e'(mode_i))
         PDIV_ONE: p_eff = P_W'(1);
         PDIV_BIT: p_eff = coef_i[PSEL_BIT] ? P_W'(2) : P_W'(1);
         default:  p_eff = (p_fld == '0) ? P_W'(1) : p_fld;
      endcase
   end

   assign frac_sum  = frac_i + FRAC_W'(FRAC_OFFSET);
   assign prod_int  = INTER_W'(ref_i) * INTER_W'(n_fld);
   assign prod_frac = INTER_W'(ref_i) * INTER_W'(frac_sum);
   assign num_o     = prod_int + (prod_frac >> FRAC_SHIFT);
   assign den_o     = DEN_W'(m_fld) * DEN_W'(p_eff);
   assign zero_o    = !ctrl_i[EN_BIT] || (m_fld == '0);
endmodule

// File: rtl/pllf_divider.sv
module pllf_divider #(
   parameter int NUM_W = 48,
   parameter int DEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             busy,
   output logic             fin,
   output logic [NUM_W-1:0] quo
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("NUM_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [DEN_W-1:0] rem;
   logic [DEN_W-1:0] den_q;
   logic [NUM_W-1:0] q;
   logic [DEN_W:0]   trial;
   logic             take;

   assign trial = {rem, q[NUM_W-1]};
   assign take  = trial >= {1'b0, den_q};
   assign busy  = cnt != '0;
   assign quo   = q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rem   <= '0;
         den_q <= '0;
         q     <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            cnt   <= CNT_W'(NUM_W);
            rem   <= '0;
            q     <= num_i;
            den_q <= den_i;
         end else if (cnt != '0) begin
            rem <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            q   <= {q[NUM_W-2:0], take};
            cnt <= cnt - CNT_W'(1);
            fin <= (cnt == CNT_W'(1));
         end
      end
   end

   // R1: the partial remainder never reaches the divisor once the quotient is final
   a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem < den_q));

   // R9: a load always starts an iteration run
   a_r9_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
endmodule

// File: rtl/pllf_decoder.sv
module pllf_decoder #(
   parameter int WORD_W      = 32,
   parameter int REF_W       = 32,
   parameter int OUT_W       = 32,
   parameter int FRAC_W      = 16,
   parameter int INTER_W     = 48,
   parameter int P_LSB       = 16,
   parameter int P_W         = 6,
   parameter int N_LSB       = 8,
   parameter int N_W         = 8,
   parameter int M_LSB       = 0,
   parameter int M_W         = 8,
   parameter int PSEL_BIT    = 28,
   parameter int EN_BIT      = 0,
   parameter int FRAC_OFFSET = 4096,
   parameter int FRAC_SHIFT  = 13,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] ctrl_word,
   input  logic [WORD_W-1:0] coef_word,
   input  logic [1:0]        pdiv_mode,
   input  logic [REF_W-1:0]  ref_khz,
   input  logic [FRAC_W-1:0] frac_word,
   output logic              done,
   output logic [OUT_W-1:0]  freq_khz
);
   localparam int DEN_W = M_W + P_W;

   if (OUT_W >= INTER_W) begin : g_bad_out
      $error("OUT_W must be narrower than INTER_W");
   end
   if (PSEL_BIT >= WORD_W || EN_BIT >= WORD_W) begin : g_bad_bits
      $error("control bit positions outside the word");
   end

   logic [INTER_W-1:0] num;
   logic [DEN_W-1:0]   den;
   logic               zero;
   logic               div_busy;
   logic               div_fin;
   logic [INTER_W-1:0] div_quo;
   logic               zpend;
   logic               active;
   logic               accept;
   logic [OUT_W-1:0]   fitted;
   logic               done_q;
   logic [OUT_W-1:0]   freq_q;

   pllf_operand #(
      .WORD_W(WORD_W), .REF_W(REF_W), .FRAC_W(FRAC_W), .INTER_W(INTER_W),
      .P_LSB(P_LSB), .P_W(P_W), .N_LSB(N_LSB), .N_W(N_W),
      .M_LSB(M_LSB), .M_W(M_W), .PSEL_BIT(PSEL_BIT), .EN_BIT(EN_BIT),
      .FRAC_OFFSET(FRAC_OFFSET), .FRAC_SHIFT(FRAC_SHIFT)
   ) i_operand (
      .ctrl_i (ctrl_word),
      .coef_i (coef_word),
      .mode_i (pdiv_mode),
      .ref_i  (ref_khz),
      .frac_i (frac_word),
      .num_o  (num),
      .den_o  (den),
      .zero_o (zero)
   );

   assign active = div_busy || zpend;
   assign accept = start && !active;

   pllf_divider #(
      .NUM_W(INTER_W), .DEN_W(DEN_W)
   ) i_divider (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && !zero),
      .num_i (num),
      .den_i (den),
      .busy  (div_busy),
      .fin   (div_fin),
      .quo   (div_quo)
   );

   if (SATURATE) begin : g_saturate
      assign fitted = (|div_quo[INTER_W-1:OUT_W]) ? '1 : div_quo[OUT_W-1:0];
   end else begin : g_truncate
      assign fitted = div_quo[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zpend  <= 1'b0;
         done_q <= 1'b0;
         freq_q <= '0;
      end else begin
         zpend  <= accept && zero;
         done_q <= div_fin || zpend;
         if (zpend) begin
            freq_q <= '0;
         end else if (div_fin) begin
            freq_q <= fitted;
         end
      end
   end

   assign done     = done_q;
   assign freq_khz = freq_q;

   // R9: the completion strobe lasts one cycle
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: a disabled loop reports zero on the fast path
   a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active && !ctrl_word[EN_BIT]) |=> ##1 (done && freq_khz == '0));

   // R7: a zero pre-divider reports zero on the fast path
   a_r7_mzero: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !active && coef_word[M_LSB +: M_W] == '0) |=> ##1 (done && freq_khz == '0));

   // R10: while a request runs, the divider keeps going and no fast-path result appears
   a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (start && div_busy && !div_fin) |=> !zpend);

   // R9: the result only changes together with the strobe
   a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(freq_khz));
endmodule

// File: tb/test_pllf_decoder.sv
`timescale 1ns/1ps
module test_pllf_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic [31:0] coef_word = '0;
   logic [1:0]  pdiv_mode = '0;
   logic [31:0] ref_khz = '0;
   logic [15:0] frac_word = '0;
   logic        done;
   logic [31:0] freq_khz;

   int          n_checks = 0;
   int          n_errors = 0;
   int          n_done = 0;
   int          n_pushed = 0;
   int          cycles = 0;
   logic        prev_done = 1'b0;
   logic [31:0] last_exp = '0;
   logic [31:0] exp_v[$];
   string       exp_tag[$];

   always #2.5 clk = ~clk;

   pllf_decoder i_pllf_decoder (
      .clk(clk), .rst_n(rst_n), .start(start),
      .ctrl_word(ctrl_word), .coef_word(coef_word), .pdiv_mode(pdiv_mode),
      .ref_khz(ref_khz), .frac_word(frac_word),
      .done(done), .freq_khz(freq_khz)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] k,
                                         input logic [1:0] md, input logic [31:0] r,
                                         input logic [15:0] f);
      logic [63:0] num, den, q;
      logic [5:0]  p;
      logic [15:0] fs;
      if (!c[0] || k[7:0] == 8'd0) return 32'd0;
      case (md)
         2'd1:    p = 6'd1;
         2'd2:    p = k[28] ? 6'd2 : 6'd1;
         default: p = (k[21:16] == 6'd0) ? 6'd1 : k[21:16];
      endcase
      fs  = f + 16'h1000;
      num = 64'(r) * 64'(k[15:8]) + ((64'(fs) * 64'(r)) >> 13);
      den = 64'(k[7:0]) * 64'(p);
      q   = num / den;
      return (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
   endfunction

   function automatic logic [31:0] mk(input logic b28, input logic [5:0] p,
                                      input logic [7:0] n, input logic [7:0] m);
      return {3'b0, b28, 6'b0, p, n, m};
   endfunction

   // monitor: pop and compare on every completion strobe
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (done && prev_done) check(1'b0, "R9 done longer than one cycle", 32'd1, 32'd0);
         if (done) begin
            n_done++;
            if (exp_v.size() == 0) begin
               check(1'b0, "R10 unexpected result", freq_khz, 32'd0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_v.pop_front();
               t = exp_tag.pop_front();
               check(freq_khz == e, t, freq_khz, e);
            end
         end
      end
      prev_done = done;
   end

   task automatic issue(input logic [31:0] c, input logic [31:0] k, input logic [1:0] md,
                        input logic [31:0] r, input logic [15:0] f);
      @(negedge clk);
      ctrl_word = c; coef_word = k; pdiv_mode = md; ref_khz = r; frac_word = f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_case(input logic [31:0] c, input logic [31:0] k, input logic [1:0] md,
                           input logic [31:0] r, input logic [15:0] f, input string tag);
      last_exp = model(c, k, md, r, f);
      exp_v.push_back(last_exp);
      exp_tag.push_back(tag);
      n_pushed++;
      issue(c, k, md, r, f);
      wait (exp_v.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      wait (cycles > 150000);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      logic [31:0] s;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R12 done after reset", {31'b0, done}, 32'd0);
      check(freq_khz == 32'd0, "R12 freq after reset", freq_khz, 32'd0);
      rst_n = 1'b1;

      run_case(32'd1, mk(0, 6'd2, 8'd100, 8'd3), 2'd0, 32'd27000, 16'hF000, "R1 field decode");
      check(freq_khz == 32'd450000, "R1 known value", freq_khz, 32'd450000);
      repeat (5) @(negedge clk);
      check(freq_khz == last_exp, "R9 result held", freq_khz, last_exp);
      run_case(32'd1, mk(0, 6'd7, 8'd200, 8'd13), 2'd0, 32'd38400, 16'hF000, "R1 field decode second");
      run_case(32'd0, mk(0, 6'd2, 8'd100, 8'd3), 2'd0, 32'd27000, 16'hF000, "R2 disabled");
      run_case(32'hFFFF_FFFE, mk(1, 6'd1, 8'd10, 8'd1), 2'd2, 32'd50000, 16'h1000, "R2 disabled bit0 clear");
      run_case(32'd1, mk(0, 6'd0, 8'd50, 8'd2), 2'd0, 32'd100000, 16'hF000, "R3 P zero as one");
      run_case(32'd1, mk(0, 6'd5, 8'd40, 8'd1), 2'd1, 32'd27000, 16'hF000, "R4 forced one");
      check(freq_khz == 32'd1080000, "R4 known value", freq_khz, 32'd1080000);
      run_case(32'd1, mk(1, 6'd7, 8'd64, 8'd2), 2'd2, 32'd100000, 16'hF000, "R5 bit set");
      check(freq_khz == 32'd1600000, "R5 bit set value", freq_khz, 32'd1600000);
      run_case(32'd1, mk(0, 6'd7, 8'd64, 8'd2), 2'd2, 32'd100000, 16'hF000, "R5 bit clear");
      check(freq_khz == 32'd3200000, "R5 bit clear value", freq_khz, 32'd3200000);
      run_case(32'd1, mk(0, 6'd1, 8'd10, 8'd1), 2'd0, 32'd27000, 16'h1000, "R6 frac adds ref");
      check(freq_khz == 32'd297000, "R6 known value", freq_khz, 32'd297000);
      run_case(32'd1, mk(0, 6'd1, 8'd10, 8'd1), 2'd0, 32'd27000, 16'hFFFF, "R6 frac wrap");
      run_case(32'd1, mk(0, 6'd3, 8'd77, 8'd5), 2'd0, 32'd19200, 16'h7A31, "R6 frac general");
      run_case(32'd1, mk(1, 6'd3, 8'd77, 8'd0), 2'd0, 32'd19200, 16'hF000, "R7 M zero");
      run_case(32'd1, mk(1, 6'd3, 8'd77, 8'd0), 2'd2, 32'd19200, 16'h1000, "R7 M zero bit mode");
      run_case(32'd1, mk(0, 6'd1, 8'd255, 8'd1), 2'd1, 32'hFFFF_FFFF, 16'h1000, "R8 saturation");
      check(freq_khz == 32'hFFFF_FFFF, "R8 saturated value", freq_khz, 32'hFFFF_FFFF);
      run_case(32'd1, mk(1, 6'd0, 8'd90, 8'd4), 2'd3, 32'd27000, 16'hF000, "R11 mode three P zero");
      run_case(32'd1, mk(1, 6'd6, 8'd90, 8'd4), 2'd3, 32'd27000, 16'hF000, "R11 mode three field");

      // R10: second start during a running division must vanish
      last_exp = model(32'd1, mk(0, 6'd2, 8'd120, 8'd3), 2'd0, 32'd27000, 16'hF000);
      exp_v.push_back(last_exp);
      exp_tag.push_back("R10 first request kept");
      n_pushed++;
      issue(32'd1, mk(0, 6'd2, 8'd120, 8'd3), 2'd0, 32'd27000, 16'hF000);
      repeat (3) @(negedge clk);
      issue(32'd0, mk(0, 6'd1, 8'd1, 8'd0), 2'd1, 32'd5, 16'h1000);
      wait (exp_v.size() == 0);
      repeat (70) @(negedge clk);
      check(n_done == n_pushed, "R10 result count", n_done, n_pushed);
      check(freq_khz == last_exp, "R10 result untouched", freq_khz, last_exp);

      s = 32'h1234_5678;
      for (int i = 0; i < 24; i++) begin
         logic [31:0] kk, rr;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         kk = s;
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         rr = (i % 3 == 0) ? s : {8'b0, s[23:0]};
         run_case({31'b0, (i % 7 != 0)}, kk, kk[31:30], rr, s[15:0], "R1 mixed operands");
      end

      check(n_done == n_pushed, "R9 one strobe per request", n_done, n_pushed);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule